// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Responder (Read-Only Image)

This block answers a bus master that bit-bangs a two-wire serial bus. It sees the sampled levels of the clock and data lines once per system clock and returns the level it wants on the data line: 1 to release the line, 0 to pull it low. Inside sits a 256-byte read-only array whose contents are set by a parameter. The default contents begin with a memory-module presence-detect header.

A transfer begins with a start condition followed by eight command bits. The last of these bits picks the direction. The responder pulls the line low in the ninth slot as its acknowledge. For a write-direction command, the next eight bits, most significant first, form the word address. The responder then fetches that byte into its data register and acknowledges a second time. For a read-direction command, the next eight slots carry the data register out most significant bit first, after which the address advances by one and the next byte is fetched. Sequencing runs on a slot counter rather than a full protocol state machine.

Top module: `spd_eeprom_slave`

## Requirements
- R1: Out of reset the data output is 1 (released), the word address is 0, and the data register already holds byte 0 of the image, so a read issued straight after reset returns byte 0.
- R2: A falling data line while the clock line stays high is a start. It restarts the command at its first bit, even when it arrives in the middle of a transfer.
- R3: With no transfer in progress (slot counter at zero and no acknowledge pending), clock pulses are ignored. The output stays 1 and the address is not changed.
- R4: A bit is taken only on a step where the clock line goes from 0 to 1 while the data line holds the level it had on the previous step. A bit whose data level changes on that same step is dropped and does not advance the slot counter.
- R5: After eight accepted command bits, the next clock-high phase has the output at 0 (acknowledge), and the output returns to 1 once the clock falls.
- R6: If the last command bit is 0 (write direction), the next eight accepted bits, MSB first, replace the word address. The byte at that address is loaded into the data register, and the following clock-high phase carries an acknowledge of 0.
- R7: If the last command bit is 1 (read direction), each of the next eight clock-high phases drives one bit of the data register, MSB first. The output is 1 during every clock-low phase. An acknowledge of 0 follows in the next high phase.
- R8: After a read byte, the address advances by one (255 wraps to 0) and the byte at the new address is loaded, so back-to-back read transfers return consecutive bytes.
- R9: Default image: bytes 0 to 7 are 0x80, 0x08, 0x04, 0x0D, 0x0A, 0x01, 0x40, 0x00, and each byte i from 8 to 255 equals i XOR 0x5A.
- R10: A rising data line while the clock line stays high is a stop. It abandons any transfer in progress, after which clocked bits draw no acknowledge and drive nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; both bus lines are sampled once per rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Sampled level of the bus clock line |
| sda_i | input | 1 | Sampled level of the bus data line |
| sda_o | output | 1 | Level the responder drives on the data line; 1 means released |

## Verification
The sequencer is driven with whole address-set and read transfers over random word addresses. Each byte returned is compared with the image formula, which separates correct address capture and MSB-first shifting from bit-order or off-by-one slips. Directed patterns cover the rest:
- back-to-back reads from address 0 and from 255, which expose a missing increment or a missing wrap;
- clock pulses with no start and clock pulses after a stop cut a command short, which expose a counter that keeps running;
- a repeated start inside a command, which must restart the count;
- an address bit whose data level changes on the same step as the clock rise, which must be dropped and not shifted in.

// File: rtl/spd_rom_pkg.sv
`timescale 1ns/1ps
package spd_rom_pkg;

    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned ADDR_W    = 8;
    localparam int unsigned ROM_DEPTH = 1 << ADDR_W;
    localparam int unsigned ROM_BITS  = BYTE_W * ROM_DEPTH;
    // slot index at which the command byte is complete
    localparam int unsigned CMD_END   = BYTE_W + 1;
    // slot index at which the address or data byte is complete
    localparam int unsigned BYTE_END  = CMD_END + ADDR_W;
    localparam int unsigned TICK_W    = $clog2(BYTE_END + 1);

    localparam int unsigned HEAD_LEN  = 8;
    localparam logic [HEAD_LEN*BYTE_W-1:0] SPD_HEAD = 64'h80_08_04_0D_0A_01_40_00;
    localparam logic [BYTE_W-1:0] FILL_KEY = 8'h5A;

    typedef struct packed {
        logic [TICK_W-1:0] tick;
        logic              ack;
        logic              rd_mode;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
        logic              sda_out;
    } seq_state_t;

    typedef struct packed {
        logic scl;
        logic sda;
    } line_state_t;

    function automatic logic [ROM_BITS-1:0] default_image();
        logic [ROM_BITS-1:0] img;
        img = '0;
        for (int i = 0; i < ROM_DEPTH; i++) begin
            if (i < HEAD_LEN)
                img[i*BYTE_W +: BYTE_W] = SPD_HEAD[(HEAD_LEN-1-i)*BYTE_W +: BYTE_W];
            else
                img[i*BYTE_W +: BYTE_W] = BYTE_W'(i) ^ FILL_KEY;
        end
        return img;
    endfunction

endpackage

// File: rtl/spd_line_sampler.sv
`timescale 1ns/1ps
module spd_line_sampler
    import spd_rom_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o,
    output logic bit_ok_o,
    output logic bit_val_o
);

    line_state_t line_d, line_q;

    always_comb begin
        line_d.scl = scl_i;
        line_d.sda = sda_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            line_q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            line_q <= line_d;
        end
    end

    always_comb begin
        scl_rise_o = !line_q.scl && scl_i;
        scl_fall_o = line_q.scl && !scl_i;
        start_o    = line_q.scl && scl_i && line_q.sda && !sda_i;
        stop_o     = line_q.scl && scl_i && !line_q.sda && sda_i;
        bit_ok_o   = scl_rise_o && (line_q.sda == sda_i);
        bit_val_o  = sda_i;
    end

    // R2 R10: a bus condition never coincides with a clock edge
    cond_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_o || stop_o) |-> !(scl_rise_o || scl_fall_o));

endmodule

// File: rtl/spd_rom.sv
`timescale 1ns/1ps
module spd_rom
    import spd_rom_pkg::*;
#(
    parameter logic [ROM_BITS-1:0] INIT_IMAGE = default_image()
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [BYTE_W-1:0] data_o
);

    logic [BYTE_W-1:0] cell_w [ROM_DEPTH];

    for (genvar g = 0; g < ROM_DEPTH; g++) begin : g_cell
        assign cell_w[g] = INIT_IMAGE[g*BYTE_W +: BYTE_W];
    end

    assign data_o = cell_w[addr_i];

endmodule

// File: rtl/spd_eeprom_slave.sv
`timescale 1ns/1ps
module spd_eeprom_slave
    import spd_rom_pkg::*;
#(
    parameter logic [ROM_BITS-1:0] INIT_IMAGE = default_image()
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o
);

    localparam logic [TICK_W-1:0] TICK_CMD  = TICK_W'(CMD_END);
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(BYTE_END - 1);
    localparam logic [TICK_W-1:0] TICK_ONE  = TICK_W'(1);

    logic scl_rise, scl_fall, start_seen, stop_seen, bit_ok, bit_val;
    logic [ADDR_W-1:0] lookup_addr;
    logic [BYTE_W-1:0] rom_data;

    seq_state_t st_d, st_q;

    spd_line_sampler u_sampler (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_seen),
        .stop_o     (stop_seen),
        .bit_ok_o   (bit_ok),
        .bit_val_o  (bit_val)
    );

    spd_rom #(
        .INIT_IMAGE (INIT_IMAGE)
    ) u_rom (
        .addr_i (lookup_addr),
        .data_o (rom_data)
    );

    // fetch address used when a byte completes
    always_comb begin
        if (st_q.rd_mode)
            lookup_addr = st_q.addr + ADDR_W'(1);
        else
            lookup_addr = {st_q.addr[ADDR_W-2:0], bit_val};
    end

    always_comb begin
        st_d = st_q;
        if (start_seen) begin
            st_d.tick    = TICK_ONE;
            st_d.ack     = 1'b0;
            st_d.sda_out = 1'b1;
        end else if (stop_seen) begin
            st_d.tick    = '0;
            st_d.ack     = 1'b0;
            st_d.sda_out = 1'b1;
        end else if (scl_fall) begin
            st_d.sda_out = 1'b1;
        end else if (scl_rise && (st_q.tick != '0 || st_q.ack)) begin
            if (st_q.ack) begin
                st_d.sda_out = 1'b0;
                st_d.ack     = 1'b0;
            end else if (bit_ok) begin
                if (st_q.tick < TICK_CMD) begin
                    st_d.rd_mode = bit_val;
                    st_d.tick    = st_q.tick + TICK_ONE;
                    if (st_q.tick == TICK_CMD - TICK_ONE)
                        st_d.ack = 1'b1;
                end else begin
                    if (st_q.rd_mode) begin
                        st_d.sda_out = st_q.data[BYTE_W-1];
                        st_d.data    = {st_q.data[BYTE_W-2:0], 1'b0};
                    end else begin
                        st_d.addr = {st_q.addr[ADDR_W-2:0], bit_val};
                    end
                    if (st_q.tick == TICK_LAST) begin
                        st_d.data = rom_data;
                        st_d.ack  = 1'b1;
                        st_d.tick = '0;
                        if (st_q.rd_mode)
                            st_d.addr = lookup_addr;
                    end else begin
                        st_d.tick = st_q.tick + TICK_ONE;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.tick    <= '0;
            st_q.ack     <= 1'b0;
            st_q.rd_mode <= 1'b0;
            st_q.addr    <= '0;
            st_q.data    <= INIT_IMAGE[BYTE_W-1:0];
            st_q.sda_out <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_o = st_q.sda_out;

    // R2
    start_rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_seen |=> (st_q.tick == TICK_ONE && !st_q.ack));

    // R10
    stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_seen |=> (st_q.tick == '0 && !st_q.ack && sda_o));

    // R3
    idle_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.tick == '0 && !st_q.ack) |=> $stable(st_q.addr));

    // R5
    drive_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sda_o) |-> $past(scl_rise));

    // R7
    release_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        scl_fall |=> sda_o);

    // R5 R6
    ack_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.ack |-> (st_q.tick == TICK_CMD || st_q.tick == '0));

endmodule

// File: tb/spd_eeprom_slave_tb_top.sv
`timescale 1ns/1ps
module spd_eeprom_slave_tb_top;

    localparam int PHASE = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_r = 1'b1;
    logic sda_r = 1'b1;
    logic sda_w;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    spd_eeprom_slave dut_i (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .scl_i  (scl_r),
        .sda_i  (sda_r),
        .sda_o  (sda_w)
    );

    function automatic logic [7:0] exp_byte(input logic [7:0] a);
        logic [63:0] head;
        head = 64'h80_08_04_0D_0A_01_40_00;
        if (a < 8) return head[(7 - a)*8 +: 8];
        return a ^ 8'h5A;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic c, input logic d);
        scl_r = c;
        sda_r = d;
        repeat (PHASE) @(negedge clk);
    endtask

    task automatic bus_start();
        put(0, 1); put(1, 1); put(1, 0); put(0, 0);
    endtask

    task automatic bus_stop();
        put(0, 0); put(1, 0); put(1, 1);
    endtask

    task automatic send_bit(input logic b);
        put(0, b); put(1, b); put(0, b);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    task automatic ack_slot(input string req);
        put(0, 1); put(1, 1);
        chk(req, sda_w, 1'b0);
        put(0, 1);
        chk(req, sda_w, 1'b1);
    endtask

    task automatic set_address(input logic [7:0] a);
        bus_start();
        send_byte(8'hA0);
        ack_slot("R5 command ack");
        send_byte(a);
        ack_slot("R6 address ack");
        bus_stop();
    endtask

    task automatic read_byte(output logic [7:0] got);
        bus_start();
        send_byte(8'hA1);
        ack_slot("R5 read command ack");
        for (int i = 7; i >= 0; i--) begin
            put(0, 1); put(1, 1);
            got[i] = sda_w;
            put(0, 1);
            chk("R7 released in low phase", sda_w, 1'b1);
        end
        ack_slot("R7 ack after data");
        bus_stop();
    endtask

    task automatic quiet_pulses(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            put(0, 0); put(1, 0);
            chk(req, sda_w, 1'b1);
        end
        put(0, 0);
        put(0, 1);
        put(1, 1);
    endtask

    initial begin
        logic [7:0] got;
        logic [7:0] a;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 reset output released", sda_w, 1'b1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle after reset", sda_w, 1'b1);

        // R1: read straight after reset gives byte 0, then byte 1
        read_byte(got); chk("R1 first read", got, exp_byte(8'd0));
        read_byte(got); chk("R8 next read", got, exp_byte(8'd1));

        // R9: header bytes through sequential reads
        set_address(8'd0);
        for (int k = 0; k < 8; k++) begin
            read_byte(got);
            chk("R9 header byte", got, exp_byte(8'(k)));
        end

        // R8: wrap from 255 to 0
        set_address(8'hFF);
        read_byte(got); chk("R8 byte 255", got, exp_byte(8'hFF));
        read_byte(got); chk("R8 wrap to 0", got, exp_byte(8'h00));

        // R6 R7: random addresses
        for (int k = 0; k < 24; k++) begin
            a = 8'($urandom);
            set_address(a);
            read_byte(got);
            chk("R6 random address read", got, exp_byte(a));
        end

        // R3: pulses without a start; address must stay put
        set_address(8'h40);
        quiet_pulses(10, "R3 no drive without start");
        read_byte(got); chk("R3 address kept", got, exp_byte(8'h40));

        // R10: stop in the middle of a command
        bus_start();
        send_bit(1); send_bit(0); send_bit(1); send_bit(0);
        bus_stop();
        quiet_pulses(10, "R10 no drive after stop");
        read_byte(got); chk("R10 address kept", got, exp_byte(8'h41));

        // R2: repeated start inside a command restarts the count
        bus_start();
        send_bit(1); send_bit(0); send_bit(1);
        bus_start();
        send_byte(8'hA0);
        ack_slot("R2 ack after restart");
        send_byte(8'h77);
        ack_slot("R2 address ack");
        bus_stop();
        read_byte(got); chk("R2 restarted address", got, exp_byte(8'h77));

        // R4: address bit with data change on the clock-rise step is dropped
        bus_start();
        send_byte(8'hA0);
        ack_slot("R4 command ack");
        send_bit(1); send_bit(0); send_bit(0);
        put(0, 0); put(1, 1); put(0, 1);
        send_bit(1); send_bit(1); send_bit(1); send_bit(0); send_bit(0);
        ack_slot("R4 ack after eight real bits");
        bus_stop();
        read_byte(got); chk("R4 glitch bit not taken", got, exp_byte(8'h9C));

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(990_000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule